// File: doc/BRIEF.md
# Integer Register File with Alias Views

This block is the integer state store of a 64-bit processor core. It keeps a bank of general registers, a bank of control registers, and a narrower status word. Several legacy 32-bit registers live inside fixed general-register slots. The block offers several ways to reach them: a plain general-register port, a control-register port, a named-alias port for the 32-bit legacy registers, and a single-bit flag port. Each way writes only the bits it owns, so the rest of the register is left as it was.

Reads are combinational and always show the contents from before the current clock edge. All write ports commit on the rising clock edge. Every write is accepted in the cycle it is presented. There is no valid/ready handshake, and no port can apply back-pressure. When several ports hit the same register in one cycle, the writes are layered in a fixed order. The full-width write goes first, then the alias write, then the flag write. Each later layer overwrites only the bits it owns.

Top module: `rfa_regfile`

## Requirements
- R1: General register 63 reads as zero on `gr_rdata`, and any write aimed at it is dropped.
- R2: Control index 0 reads as the status word, zero-extended to 64 bits. A control write to index 0 loads bits 31:0 of the write data into the status word. Every other control index is ordinary 64-bit storage.
- R3: With `gr_wnarrow`=1, a general write stores bits 31:0 of `gr_wdata`, sign-extended to 64 bits. `gr_rdata_lo` always shows bits 31:0 of the selected register.
- R4: Alias selects 0, 3 and 4 name general registers 16, 18 and 20. An alias write stores the 32-bit data sign-extended, and an alias read returns the low 32 bits. Selects 5 to 7 are reserved: their writes change nothing and their reads return 0.
- R5: Alias select 1 is bits 63:32 of general register 17, and select 2 is bits 31:0 of that register. Writing one half leaves the other half unchanged.
- R6: Flag select 0 is bit 0 of general register 19. A flag write with that select changes only that bit, and `t_flag` shows it.
- R7: Flag selects 1, 2 and 3 write status bits 1, 8 and 9, one at a time. All other status bits are kept.
- R8: When ports collide on one register in the same cycle, the full write is applied first, then the alias write, then the flag write. Each later write overwrites only its own bits.
- R9: Reads return the value from before a same-cycle write. The written value becomes visible from the next cycle.
- R10: Reset clears every general register, every control register and the status word to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| gr_raddr | input | 6 | General read index |
| gr_rdata | output | 64 | General read data |
| gr_rdata_lo | output | 32 | Low half of the general read data |
| gr_we | input | 1 | General write enable |
| gr_waddr | input | 6 | General write index |
| gr_wdata | input | 64 | General write data |
| gr_wnarrow | input | 1 | 1 = 32-bit sign-extending write |
| cr_raddr | input | 6 | Control read index |
| cr_rdata | output | 64 | Control read data |
| cr_we | input | 1 | Control write enable |
| cr_waddr | input | 6 | Control write index |
| cr_wdata | input | 64 | Control write data |
| al_rsel | input | 3 | Alias read select |
| al_rdata | output | 32 | Alias read data |
| al_we | input | 1 | Alias write enable |
| al_wsel | input | 3 | Alias write select |
| al_wdata | input | 32 | Alias write data |
| flag_we | input | 1 | Flag write enable |
| flag_sel | input | 2 | Flag select (0 T, 1 S, 2 Q, 3 M) |
| flag_val | input | 1 | Flag value to write |
| sr_o | output | 32 | Current status word |
| t_flag | output | 1 | Current T flag |

## Verification
The bench builds the block with its default parameters: 64 general registers, 64 control registers, 64-bit data and a 32-bit status word. With these values the zero slot is index 63, the alias slots 16 to 20 sit inside the bank, and the halves of the multiply-accumulate register are exactly 32 bits each. This makes every fixed slot and every bit position in the requirements reachable. The directed tests also aim deliberate same-cycle collisions at the shared slots, so that the layering order can be observed.

// File: rtl/rfa_pkg.sv
package rfa_pkg;
  // fixed general-register slots used by the alias views
  localparam int unsigned SLOT_GBASE = 16;
  localparam int unsigned SLOT_MAC   = 17;
  localparam int unsigned SLOT_RET   = 18;
  localparam int unsigned SLOT_TFLAG = 19;
  localparam int unsigned SLOT_VBASE = 20;

  // bit positions of single-bit flags
  localparam int unsigned POS_T = 0;
  localparam int unsigned POS_S = 1;
  localparam int unsigned POS_Q = 8;
  localparam int unsigned POS_M = 9;

  typedef enum logic [2:0] {
    AL_GBASE = 3'd0,
    AL_MACH  = 3'd1,
    AL_MACL  = 3'd2,
    AL_RET   = 3'd3,
    AL_VBASE = 3'd4
  } alias_e;

  typedef enum logic [1:0] {
    FL_T = 2'd0,
    FL_S = 2'd1,
    FL_Q = 2'd2,
    FL_M = 2'd3
  } flag_e;
endpackage

// File: rtl/rfa_gr_bank.sv
// General bank: masked write ports layered in port order, highest port last.
module rfa_gr_bank #(
  parameter int unsigned NREG    = 64,
  parameter int unsigned XLEN    = 64,
  parameter int unsigned NWP     = 3,
  parameter int unsigned NRP     = 2,
  parameter int unsigned TAP_IDX = 19,
  parameter int unsigned TAP_BIT = 0,
  localparam int unsigned AW       = $clog2(NREG),
  localparam int unsigned ZERO_IDX = NREG - 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NWP-1:0]                wp_en,
  input  logic [NWP-1:0][AW-1:0]        wp_idx,
  input  logic [NWP-1:0][XLEN-1:0]      wp_mask,
  input  logic [NWP-1:0][XLEN-1:0]      wp_data,
  input  logic [NRP-1:0][AW-1:0]        rp_idx,
  output logic [NRP-1:0][XLEN-1:0]      rp_data,
  output logic                          tap_bit
);
  logic [XLEN-1:0] rows [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_ent
    if (i == ZERO_IDX) begin : g_zero
      assign rows[i] = '0;
    end else begin : g_store
      logic [XLEN-1:0] q;
      logic [XLEN-1:0] d;
      always_comb begin
        d = q;
        for (int p = 0; p < NWP; p++) begin
          if (wp_en[p] && wp_idx[p] == AW'(i))
            d = (d & ~wp_mask[p]) | (wp_data[p] & wp_mask[p]);
        end
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
      end
      assign rows[i] = q;
    end
  end

  for (genvar r = 0; r < NRP; r++) begin : g_rd
    assign rp_data[r] = (rp_idx[r] == AW'(ZERO_IDX)) ? '0 : rows[rp_idx[r]];
  end

  assign tap_bit = rows[TAP_IDX][TAP_BIT];
endmodule

// File: rtl/rfa_cr_bank.sv
// Control bank: index 0 is the narrow status word, the rest plain storage.
module rfa_cr_bank #(
  parameter int unsigned NCR  = 64,
  parameter int unsigned XLEN = 64,
  parameter int unsigned SRW  = 32,
  localparam int unsigned AW = $clog2(NCR)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cr_we,
  input  logic [AW-1:0]   cr_widx,
  input  logic [XLEN-1:0] cr_wdata,
  input  logic            fl_en,
  input  logic [SRW-1:0]  fl_mask,
  input  logic [SRW-1:0]  fl_data,
  input  logic [AW-1:0]   rd_idx,
  output logic [XLEN-1:0] rd_data,
  output logic [SRW-1:0]  sr_q
);
  logic [XLEN-1:0] rows [NCR];
  logic [SRW-1:0]  sr_d;

  // control write first, flag merge layered on top
  always_comb begin
    sr_d = sr_q;
    if (cr_we && cr_widx == '0) sr_d = cr_wdata[SRW-1:0];
    if (fl_en) sr_d = (sr_d & ~fl_mask) | (fl_data & fl_mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

  for (genvar i = 0; i < NCR; i++) begin : g_ent
    if (i == 0) begin : g_status
      assign rows[i] = {{(XLEN-SRW){1'b0}}, sr_q};
    end else begin : g_store
      logic [XLEN-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          q <= '0;
        else if (cr_we && cr_widx == AW'(i)) q <= cr_wdata;
      end
      assign rows[i] = q;
    end
  end

  assign rd_data = rows[rd_idx];
endmodule

// File: rtl/rfa_alias_map.sv
// Turns alias and flag requests into masked writes and selects alias reads.
module rfa_alias_map
  import rfa_pkg::*;
#(
  parameter int unsigned NREG = 64,
  parameter int unsigned XLEN = 64,
  parameter int unsigned SRW  = 32,
  localparam int unsigned AW = $clog2(NREG),
  localparam int unsigned HW = XLEN / 2
) (
  input  logic            al_we,
  input  logic [2:0]      al_wsel,
  input  logic [HW-1:0]   al_wdata,
  input  logic            flag_we,
  input  logic [1:0]      flag_sel,
  input  logic            flag_val,
  input  logic [2:0]      al_rsel,
  input  logic [XLEN-1:0] al_rrow,
  output logic            aw_en,
  output logic [AW-1:0]   aw_idx,
  output logic [XLEN-1:0] aw_mask,
  output logic [XLEN-1:0] aw_data,
  output logic            tw_en,
  output logic [AW-1:0]   tw_idx,
  output logic [XLEN-1:0] tw_mask,
  output logic [XLEN-1:0] tw_data,
  output logic            sf_en,
  output logic [SRW-1:0]  sf_mask,
  output logic [SRW-1:0]  sf_data,
  output logic [AW-1:0]   ar_idx,
  output logic [HW-1:0]   al_rdata
);
  logic [XLEN-1:0] sext_w;
  assign sext_w = {{HW{al_wdata[HW-1]}}, al_wdata};

  always_comb begin
    aw_en   = al_we;
    aw_idx  = AW'(SLOT_GBASE);
    aw_mask = '1;
    aw_data = sext_w;
    case (al_wsel)
      3'(AL_GBASE): aw_idx = AW'(SLOT_GBASE);
      3'(AL_RET):   aw_idx = AW'(SLOT_RET);
      3'(AL_VBASE): aw_idx = AW'(SLOT_VBASE);
      3'(AL_MACH): begin
        aw_idx  = AW'(SLOT_MAC);
        aw_mask = {{HW{1'b1}}, {HW{1'b0}}};
        aw_data = {al_wdata, {HW{1'b0}}};
      end
      3'(AL_MACL): begin
        aw_idx  = AW'(SLOT_MAC);
        aw_mask = {{HW{1'b0}}, {HW{1'b1}}};
        aw_data = {{HW{1'b0}}, al_wdata};
      end
      default: aw_en = 1'b0;
    endcase
  end

  logic rd_valid;
  always_comb begin
    rd_valid = 1'b1;
    ar_idx   = AW'(SLOT_GBASE);
    case (al_rsel)
      3'(AL_GBASE):             ar_idx = AW'(SLOT_GBASE);
      3'(AL_RET):               ar_idx = AW'(SLOT_RET);
      3'(AL_VBASE):             ar_idx = AW'(SLOT_VBASE);
      3'(AL_MACH), 3'(AL_MACL): ar_idx = AW'(SLOT_MAC);
      default:                  rd_valid = 1'b0;
    endcase
  end

  assign al_rdata = !rd_valid                 ? '0 :
                    (al_rsel == 3'(AL_MACH))  ? al_rrow[XLEN-1:HW] :
                                                al_rrow[HW-1:0];

  assign tw_en   = flag_we && (flag_sel == 2'(FL_T));
  assign tw_idx  = AW'(SLOT_TFLAG);
  assign tw_mask = XLEN'(1) << POS_T;
  assign tw_data = XLEN'(flag_val) << POS_T;

  always_comb begin
    sf_mask = '0;
    case (flag_sel)
      2'(FL_S): sf_mask = SRW'(1) << POS_S;
      2'(FL_Q): sf_mask = SRW'(1) << POS_Q;
      2'(FL_M): sf_mask = SRW'(1) << POS_M;
      default:  sf_mask = '0;
    endcase
  end
  assign sf_en   = flag_we && (flag_sel != 2'(FL_T));
  assign sf_data = {SRW{flag_val}} & sf_mask;
endmodule

// File: rtl/rfa_regfile.sv
module rfa_regfile
  import rfa_pkg::*;
#(
  parameter int unsigned NUM_GR = 64,
  parameter int unsigned NUM_CR = 64,
  parameter int unsigned XLEN   = 64,
  parameter int unsigned SRW    = 32,
  localparam int unsigned GAW = $clog2(NUM_GR),
  localparam int unsigned CAW = $clog2(NUM_CR),
  localparam int unsigned HW  = XLEN / 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [GAW-1:0]  gr_raddr,
  output logic [XLEN-1:0] gr_rdata,
  output logic [HW-1:0]   gr_rdata_lo,
  input  logic            gr_we,
  input  logic [GAW-1:0]  gr_waddr,
  input  logic [XLEN-1:0] gr_wdata,
  input  logic            gr_wnarrow,
  input  logic [CAW-1:0]  cr_raddr,
  output logic [XLEN-1:0] cr_rdata,
  input  logic            cr_we,
  input  logic [CAW-1:0]  cr_waddr,
  input  logic [XLEN-1:0] cr_wdata,
  input  logic [2:0]      al_rsel,
  output logic [HW-1:0]   al_rdata,
  input  logic            al_we,
  input  logic [2:0]      al_wsel,
  input  logic [HW-1:0]   al_wdata,
  input  logic            flag_we,
  input  logic [1:0]      flag_sel,
  input  logic            flag_val,
  output logic [SRW-1:0]  sr_o,
  output logic            t_flag
);
  localparam int unsigned NWP = 3;
  localparam int unsigned NRP = 2;

  logic            aw_en, tw_en, sf_en;
  logic [GAW-1:0]  aw_idx, tw_idx, ar_idx;
  logic [XLEN-1:0] aw_mask, aw_data, tw_mask, tw_data;
  logic [SRW-1:0]  sf_mask, sf_data;
  logic [XLEN-1:0] full_data;

  logic [NWP-1:0]            wp_en;
  logic [NWP-1:0][GAW-1:0]   wp_idx;
  logic [NWP-1:0][XLEN-1:0]  wp_mask, wp_data;
  logic [NRP-1:0][GAW-1:0]   rp_idx;
  logic [NRP-1:0][XLEN-1:0]  rp_data;

  assign full_data = gr_wnarrow ? {{HW{gr_wdata[HW-1]}}, gr_wdata[HW-1:0]} : gr_wdata;

  rfa_alias_map #(.NREG(NUM_GR), .XLEN(XLEN), .SRW(SRW)) u_map (
    .al_we(al_we), .al_wsel(al_wsel), .al_wdata(al_wdata),
    .flag_we(flag_we), .flag_sel(flag_sel), .flag_val(flag_val),
    .al_rsel(al_rsel), .al_rrow(rp_data[1]),
    .aw_en(aw_en), .aw_idx(aw_idx), .aw_mask(aw_mask), .aw_data(aw_data),
    .tw_en(tw_en), .tw_idx(tw_idx), .tw_mask(tw_mask), .tw_data(tw_data),
    .sf_en(sf_en), .sf_mask(sf_mask), .sf_data(sf_data),
    .ar_idx(ar_idx), .al_rdata(al_rdata)
  );

  // port order is priority order: later ports are merged last
  assign wp_en   = {tw_en,   aw_en,   gr_we};
  assign wp_idx  = {tw_idx,  aw_idx,  gr_waddr};
  assign wp_mask = {tw_mask, aw_mask, {XLEN{1'b1}}};
  assign wp_data = {tw_data, aw_data, full_data};
  assign rp_idx  = {ar_idx, gr_raddr};

  rfa_gr_bank #(
    .NREG(NUM_GR), .XLEN(XLEN), .NWP(NWP), .NRP(NRP),
    .TAP_IDX(SLOT_TFLAG), .TAP_BIT(POS_T)
  ) u_gr (
    .clk(clk), .rst_n(rst_n),
    .wp_en(wp_en), .wp_idx(wp_idx), .wp_mask(wp_mask), .wp_data(wp_data),
    .rp_idx(rp_idx), .rp_data(rp_data), .tap_bit(t_flag)
  );

  rfa_cr_bank #(.NCR(NUM_CR), .XLEN(XLEN), .SRW(SRW)) u_cr (
    .clk(clk), .rst_n(rst_n),
    .cr_we(cr_we), .cr_widx(cr_waddr), .cr_wdata(cr_wdata),
    .fl_en(sf_en), .fl_mask(sf_mask), .fl_data(sf_data),
    .rd_idx(cr_raddr), .rd_data(cr_rdata), .sr_q(sr_o)
  );

  assign gr_rdata    = rp_data[0];
  assign gr_rdata_lo = rp_data[0][HW-1:0];
endmodule

// File: rtl/rfa_regfile_chk.sv
module rfa_regfile_chk
  import rfa_pkg::*;
#(
  parameter int unsigned NUM_GR = 64,
  parameter int unsigned NUM_CR = 64,
  parameter int unsigned XLEN   = 64,
  parameter int unsigned SRW    = 32,
  localparam int unsigned GAW = $clog2(NUM_GR),
  localparam int unsigned CAW = $clog2(NUM_CR),
  localparam int unsigned HW  = XLEN / 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic [GAW-1:0]  gr_raddr,
  input logic [XLEN-1:0] gr_rdata,
  input logic            gr_we,
  input logic [GAW-1:0]  gr_waddr,
  input logic [XLEN-1:0] gr_wdata,
  input logic            gr_wnarrow,
  input logic [CAW-1:0]  cr_raddr,
  input logic [XLEN-1:0] cr_rdata,
  input logic            cr_we,
  input logic [CAW-1:0]  cr_waddr,
  input logic [2:0]      al_rsel,
  input logic [HW-1:0]   al_rdata,
  input logic            al_we,
  input logic [2:0]      al_wsel,
  input logic [HW-1:0]   al_wdata,
  input logic            flag_we,
  input logic [1:0]      flag_sel,
  input logic            flag_val,
  input logic            t_flag
);
  localparam logic [GAW-1:0]  ZERO  = GAW'(NUM_GR - 1);
  localparam logic [XLEN-1:0] FLAGS = (XLEN'(1) << POS_S) | (XLEN'(1) << POS_Q) | (XLEN'(1) << POS_M);

  p_zero_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
    gr_raddr == ZERO |-> gr_rdata == '0);

  p_status_view_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cr_raddr == '0 |-> cr_rdata[XLEN-1:SRW] == '0);

  p_narrow_sext_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (gr_we && gr_wnarrow && gr_waddr != ZERO && !al_we && !flag_we)
    |=> (gr_raddr != $past(gr_waddr) ||
         gr_rdata == {{HW{$past(gr_wdata[HW-1])}}, $past(gr_wdata[HW-1:0])}));

  p_alias_sext_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (al_we && al_wsel == 3'(AL_GBASE) && gr_raddr == GAW'(SLOT_GBASE))
    |=> (gr_raddr != GAW'(SLOT_GBASE) ||
         gr_rdata == {{HW{$past(al_wdata[HW-1])}}, $past(al_wdata)}));

  p_mac_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (al_we && al_wsel == 3'(AL_MACH) && !(gr_we && gr_waddr == GAW'(SLOT_MAC)) &&
     al_rsel == 3'(AL_MACL))
    |=> (al_rsel != 3'(AL_MACL) || al_rdata == $past(al_rdata)));

  p_tflag_value_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && flag_sel == 2'(FL_T) && !(gr_we && gr_waddr == GAW'(SLOT_TFLAG)))
    |=> t_flag == $past(flag_val));

  p_tflag_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && flag_sel == 2'(FL_T) && !(gr_we && gr_waddr == GAW'(SLOT_TFLAG)) &&
     gr_raddr == GAW'(SLOT_TFLAG))
    |=> (gr_raddr != GAW'(SLOT_TFLAG) || gr_rdata[XLEN-1:1] == $past(gr_rdata[XLEN-1:1])));

  p_status_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && flag_sel != 2'(FL_T) && !(cr_we && cr_waddr == '0) && cr_raddr == '0)
    |=> (cr_raddr != '0 || ((cr_rdata ^ $past(cr_rdata)) & ~FLAGS) == '0));

  p_next_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (gr_we && !gr_wnarrow && gr_waddr != ZERO && !al_we && !flag_we)
    |=> (gr_raddr != $past(gr_waddr) || gr_rdata == $past(gr_wdata)));
endmodule

bind rfa_regfile rfa_regfile_chk #(
  .NUM_GR(NUM_GR), .NUM_CR(NUM_CR), .XLEN(XLEN), .SRW(SRW)
) i_chk (.*);

// File: tb/test_rfa_regfile.sv
module test_rfa_regfile;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  gr_raddr = '0;
  logic [63:0] gr_rdata;
  logic [31:0] gr_rdata_lo;
  logic        gr_we = 1'b0;
  logic [5:0]  gr_waddr = '0;
  logic [63:0] gr_wdata = '0;
  logic        gr_wnarrow = 1'b0;
  logic [5:0]  cr_raddr = '0;
  logic [63:0] cr_rdata;
  logic        cr_we = 1'b0;
  logic [5:0]  cr_waddr = '0;
  logic [63:0] cr_wdata = '0;
  logic [2:0]  al_rsel = '0;
  logic [31:0] al_rdata;
  logic        al_we = 1'b0;
  logic [2:0]  al_wsel = '0;
  logic [31:0] al_wdata = '0;
  logic        flag_we = 1'b0;
  logic [1:0]  flag_sel = '0;
  logic        flag_val = 1'b0;
  logic [31:0] sr_o;
  logic        t_flag;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  rfa_regfile i_rfa_regfile (.*);

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic quiet();
    gr_we = 0; cr_we = 0; al_we = 0; flag_we = 0; gr_wnarrow = 0;
  endtask

  task automatic gr_write(logic [5:0] a, logic [63:0] d, logic narrow);
    gr_we = 1; gr_waddr = a; gr_wdata = d; gr_wnarrow = narrow;
    tick(); quiet();
  endtask

  task automatic cr_write(logic [5:0] a, logic [63:0] d);
    cr_we = 1; cr_waddr = a; cr_wdata = d;
    tick(); quiet();
  endtask

  task automatic al_write(logic [2:0] s, logic [31:0] d);
    al_we = 1; al_wsel = s; al_wdata = d;
    tick(); quiet();
  endtask

  task automatic fl_write(logic [1:0] s, logic v);
    flag_we = 1; flag_sel = s; flag_val = v;
    tick(); quiet();
  endtask

  task automatic gr_read(logic [5:0] a, output logic [63:0] d);
    gr_raddr = a; #1; d = gr_rdata;
  endtask

  task automatic t_reset();
    logic [63:0] v;
    gr_read(6'd5, v);  check("R10 gr5", v, 64'h0);
    gr_read(6'd17, v); check("R10 gr17", v, 64'h0);
    cr_raddr = 6'd3; #1; check("R10 cr3", cr_rdata, 64'h0);
    check("R10 status", {32'h0, sr_o}, 64'h0);
    check("R10 tflag", {63'h0, t_flag}, 64'h0);
  endtask

  task automatic t_zero();
    logic [63:0] v;
    gr_write(6'd63, 64'hFFFF_FFFF_FFFF_FFFF, 0);
    gr_read(6'd63, v); check("R1 zero slot", v, 64'h0);
    gr_read(6'd62, v); check("R1 neighbour", v, 64'h0);
  endtask

  task automatic t_narrow();
    logic [63:0] v;
    gr_write(6'd5, 64'h1234_5678_8000_0001, 1);
    gr_read(6'd5, v); check("R3 negative sext", v, 64'hFFFF_FFFF_8000_0001);
    check("R3 low view", {32'h0, gr_rdata_lo}, 64'h8000_0001);
    gr_write(6'd6, 64'hAAAA_0000_7FFF_FFFF, 1);
    gr_read(6'd6, v); check("R3 positive sext", v, 64'h0000_0000_7FFF_FFFF);
    gr_write(6'd7, 64'hCAFE_F00D_1234_ABCD, 0);
    gr_read(6'd7, v); check("R3 full write", v, 64'hCAFE_F00D_1234_ABCD);
  endtask

  task automatic t_control();
    cr_write(6'd5, 64'h0123_4567_89AB_CDEF);
    cr_raddr = 6'd5; #1; check("R2 plain cr", cr_rdata, 64'h0123_4567_89AB_CDEF);
    cr_write(6'd0, 64'hDEAD_BEEF_1234_5678);
    cr_raddr = 6'd0; #1; check("R2 status view", cr_rdata, 64'h0000_0000_1234_5678);
    check("R2 status word", {32'h0, sr_o}, 64'h1234_5678);
  endtask

  task automatic t_alias();
    logic [63:0] v;
    al_write(3'd0, 32'h8000_0010);
    gr_read(6'd16, v); check("R4 gbase sext", v, 64'hFFFF_FFFF_8000_0010);
    al_rsel = 3'd0; #1; check("R4 gbase read", {32'h0, al_rdata}, 64'h8000_0010);
    al_write(3'd3, 32'h0000_1234);
    gr_read(6'd18, v); check("R4 ret slot", v, 64'h0000_0000_0000_1234);
    gr_write(6'd20, 64'h1111_2222_3333_4444, 0);
    al_rsel = 3'd4; #1; check("R4 vbase read", {32'h0, al_rdata}, 64'h3333_4444);
    al_write(3'd5, 32'hFFFF_FFFF);
    gr_read(6'd16, v); check("R4 reserved no write gr16", v, 64'hFFFF_FFFF_8000_0010);
    gr_read(6'd20, v); check("R4 reserved no write gr20", v, 64'h1111_2222_3333_4444);
    al_rsel = 3'd5; #1; check("R4 reserved read", {32'h0, al_rdata}, 64'h0);
  endtask

  task automatic t_mac();
    logic [63:0] v;
    gr_write(6'd17, 64'h0102_0304_0506_0708, 0);
    al_write(3'd1, 32'hAABB_CCDD);
    gr_read(6'd17, v); check("R5 high write", v, 64'hAABB_CCDD_0506_0708);
    al_write(3'd2, 32'h1122_3344);
    gr_read(6'd17, v); check("R5 low write", v, 64'hAABB_CCDD_1122_3344);
    al_rsel = 3'd1; #1; check("R5 high read", {32'h0, al_rdata}, 64'hAABB_CCDD);
    al_rsel = 3'd2; #1; check("R5 low read", {32'h0, al_rdata}, 64'h1122_3344);
  endtask

  task automatic t_flags();
    logic [63:0] v;
    gr_write(6'd19, 64'hFFFF_0000_FFFF_FFF0, 0);
    fl_write(2'd0, 1);
    gr_read(6'd19, v); check("R6 T set", v, 64'hFFFF_0000_FFFF_FFF1);
    check("R6 T out", {63'h0, t_flag}, 64'h1);
    fl_write(2'd0, 0);
    gr_read(6'd19, v); check("R6 T clear", v, 64'hFFFF_0000_FFFF_FFF0);
    cr_write(6'd0, 64'h0000_0000_FFFF_FFFF);
    fl_write(2'd1, 0); check("R7 S clear", {32'h0, sr_o}, 64'hFFFF_FFFD);
    fl_write(2'd2, 0); check("R7 Q clear", {32'h0, sr_o}, 64'hFFFF_FEFD);
    fl_write(2'd3, 0); check("R7 M clear", {32'h0, sr_o}, 64'hFFFF_FCFD);
    fl_write(2'd1, 1); check("R7 S set", {32'h0, sr_o}, 64'hFFFF_FCFF);
  endtask

  task automatic t_priority();
    logic [63:0] v;
    gr_we = 1; gr_waddr = 6'd17; gr_wdata = 64'h9999_9999_9999_9999;
    al_we = 1; al_wsel = 3'd2; al_wdata = 32'h5555_5555;
    tick(); quiet();
    gr_read(6'd17, v); check("R8 full then low half", v, 64'h9999_9999_5555_5555);
    gr_we = 1; gr_waddr = 6'd16; gr_wdata = 64'hFFFF_FFFF_FFFF_FFFF;
    al_we = 1; al_wsel = 3'd0; al_wdata = 32'h0000_0042;
    tick(); quiet();
    gr_read(6'd16, v); check("R8 alias over full", v, 64'h42);
    gr_we = 1; gr_waddr = 6'd19; gr_wdata = 64'h0;
    flag_we = 1; flag_sel = 2'd0; flag_val = 1;
    tick(); quiet();
    gr_read(6'd19, v); check("R8 flag over full", v, 64'h1);
    cr_we = 1; cr_waddr = 6'd0; cr_wdata = 64'h0;
    flag_we = 1; flag_sel = 2'd3; flag_val = 1;
    tick(); quiet();
    check("R8 flag over control", {32'h0, sr_o}, 64'h200);
  endtask

  task automatic t_prewrite();
    gr_raddr = 6'd7;
    gr_we = 1; gr_waddr = 6'd7; gr_wdata = 64'h5A5A_5A5A_0000_1111;
    #1; check("R9 old value during write", gr_rdata, 64'hCAFE_F00D_1234_ABCD);
    tick(); quiet();
    check("R9 new value after edge", gr_rdata, 64'h5A5A_5A5A_0000_1111);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog (all requirements) actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_zero();
    t_narrow();
    t_control();
    t_alias();
    t_mac();
    t_flags();
    t_priority();
    t_prewrite();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule